// File: doc/BRIEF.md
# Smart-Card Serial Status Flag Unit

This block keeps the status flags and the received-byte register of a half-duplex smart-card serial interface. A receive engine outside the block gives it a one-cycle completion strobe and the finished byte. The transmit side gives it a one-cycle strobe each time it samples an error signal that the card drives back on the line. The block decides whether each finished byte is accepted. It tracks a data-full flag, an overrun flag and an error-signal flag. When an overrun happens, it decides which byte the data register holds.

Software reaches the block through a small register bus with two readable addresses, one for status and one for data. Software clears a flag by writing 0 to that flag's bit. A flag can never be set by writing, so a write of all ones leaves the flags unchanged. A protocol-select input suppresses the error-signal flag in block-oriented (T=1) mode. Dropping either enable leaves the flags that have already been raised as they are.

Top module: `scs_status_unit`

## Requirements
- R1: Reset puts the data-full, overrun and error-signal flags at 0 and the data register at 0.
- R2: A reception is accepted when receive is enabled and the overrun flag is 0. If the data-full flag was 0, an accepted reception loads the byte and sets the data-full flag in the next cycle. Reading the data address does not clear the data-full flag.
- R3: If the data-full flag is 1 when a reception is accepted, the overrun flag is set and the data register takes the new byte. The earlier byte is lost and the data-full flag stays 1.
- R4: While the overrun flag is 1, completed receptions are ignored: no flag or data changes.
- R5: A reception strobe with receive disabled is ignored. Dropping receive enable does not change the overrun flag.
- R6: The status word has the data-full flag at bit 6, the overrun flag at bit 5 and the error-signal flag at bit 4, and all other bits read 0. A write to the status address (address 0) with a 0 in a flag bit clears that flag. A 1 in that bit has no effect.
- R7: An error-signal strobe while transmit is enabled and T=0 mode is selected (mode input 0) sets the error-signal flag in the next cycle.
- R8: With T=1 mode selected (mode input 1), the error-signal flag is never set.
- R9: An error-signal strobe with transmit disabled is ignored. Dropping transmit enable does not change the error-signal flag.
- R10: When a clearing write and a set condition for the same flag fall in the same cycle, the flag ends up 1.
- R11: A read of address 0 returns the status word, a read of address 1 returns the data register, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 1 | One-cycle strobe: a character reception finished |
| rx_byte | input | DATA_W | Byte that finished with rx_done |
| rx_en | input | 1 | Receive enable |
| tx_en | input | 1 | Transmit enable |
| mode_t1 | input | 1 | 1 selects T=1 block mode, 0 selects T=0 character mode |
| err_sig | input | 1 | One-cycle strobe: an error signal was sampled during transmission |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for bus_addr |
| rx_full | output | 1 | Data-full flag |
| overrun | output | 1 | Overrun flag |
| err_flag | output | 1 | Error-signal flag |

## Verification
A software clearing write to the status word can fall in the same cycle as a hardware set: an accepted reception or a qualifying error-signal strobe. The bench provokes this by driving a write of all zeros to address 0 together with rx_done or err_sig in the same cycle. In each case it expects the flag to read 1 afterwards. One case has the data-full flag already 1, so the same cycle also raises the overrun flag and replaces the held byte. The bench then checks that the flag the write targeted without any competing set did go to 0.

// File: rtl/scs_pkg.sv
package scs_pkg;
    // Register addresses
    localparam int ADDR_STATUS = 0;
    localparam int ADDR_DATA   = 1;
    // Flag positions inside the status word
    localparam int FULL_BIT    = 6;
    localparam int OVR_BIT     = 5;
    localparam int ERR_BIT     = 4;
    localparam int MIN_DATA_W  = FULL_BIT + 1;

    typedef struct packed {
        logic full;
        logic ovr;
        logic err;
    } flag_set_t;
endpackage

// File: rtl/scs_regif.sv
module scs_regif
    import scs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  flag_set_t         flags,
    input  logic [DATA_W-1:0] rx_data,
    output logic [DATA_W-1:0] bus_rdata,
    output flag_set_t         clr
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STATUS);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(ADDR_DATA);

    logic              stat_wr;
    logic [DATA_W-1:0] status_word;

    // Status word assembly
    always_comb begin
        status_word           = '0;
        status_word[FULL_BIT] = flags.full;
        status_word[OVR_BIT]  = flags.ovr;
        status_word[ERR_BIT]  = flags.err;
    end

    // Read multiplexer
    always_comb begin
        unique case (bus_addr)
            A_STAT:  bus_rdata = status_word;
            A_DATA:  bus_rdata = rx_data;
            default: bus_rdata = '0;
        endcase
    end

    // Clear-by-writing-zero decode; a 1 never sets anything
    assign stat_wr = bus_wr && (bus_addr == A_STAT);

    always_comb begin
        clr.full = stat_wr && !bus_wdata[FULL_BIT];
        clr.ovr  = stat_wr && !bus_wdata[OVR_BIT];
        clr.err  = stat_wr && !bus_wdata[ERR_BIT];
    end
endmodule

// File: rtl/scs_rx_path.sv
module scs_rx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_en,
    input  logic              clr_full,
    input  logic              clr_ovr,
    output logic              rx_full,
    output logic              overrun,
    output logic [DATA_W-1:0] rx_data
);
    typedef struct packed {
        logic              full;
        logic              ovr;
        logic [DATA_W-1:0] data;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic      accept;

    // Reception is taken only while enabled and not blocked by overrun
    assign accept = rx_done && rx_en && !st_q.ovr;

    always_comb begin
        st_d = st_q;
        if (clr_full) st_d.full = 1'b0;
        if (clr_ovr)  st_d.ovr  = 1'b0;
        // Hardware set applied last so it wins over a same-cycle clear
        if (accept) begin
            st_d.data = rx_byte;
            st_d.full = 1'b1;
            if (st_q.full) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_full = st_q.full;
    assign overrun = st_q.ovr;
    assign rx_data = st_q.data;

    AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_en && !rx_full && !overrun) |=> (rx_full && !overrun && rx_data == $past(rx_byte))); // R2
    AST_OVR_TAKES_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_en && rx_full && !overrun) |=> (overrun && rx_full && rx_data == $past(rx_byte))); // R3
    AST_OVR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> $stable(rx_data)); // R4
    AST_RXOFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !clr_full) |=> ($stable(rx_data) && rx_full == $past(rx_full))); // R5
    AST_OVR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_ovr) |=> overrun); // R5
    AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovr && !(rx_done && rx_en && rx_full)) |=> !overrun); // R6
    AST_FULL_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_full && rx_done && rx_en && !overrun) |=> rx_full); // R10
endmodule

// File: rtl/scs_err_flag.sv
module scs_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic err_sig,
    input  logic tx_en,
    input  logic mode_t1,
    input  logic clr_err,
    output logic err_flag
);
    typedef struct packed {
        logic err;
    } err_state_t;

    err_state_t st_d, st_q;
    logic       hit;

    // Only character mode with transmit active records the error signal
    assign hit = err_sig && tx_en && !mode_t1;

    always_comb begin
        st_d = st_q;
        if (clr_err) st_d.err = 1'b0;
        if (hit)     st_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_flag = st_q.err;

    AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sig && tx_en && !mode_t1) |=> err_flag); // R7
    AST_T1_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_t1 && !err_flag) |=> !err_flag); // R8
    AST_ERR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr_err) |=> err_flag); // R9
    AST_TXOFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !err_flag) |=> !err_flag); // R9
    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !(err_sig && tx_en && !mode_t1)) |=> !err_flag); // R6
endmodule

// File: rtl/scs_status_unit.sv
module scs_status_unit
    import scs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_en,
    input  logic              tx_en,
    input  logic              mode_t1,
    input  logic              err_sig,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rx_full,
    output logic              overrun,
    output logic              err_flag
);
    flag_set_t         flags;
    flag_set_t         clr;
    logic [DATA_W-1:0] rx_data;

    initial begin
        assert (DATA_W >= MIN_DATA_W);
        assert (ADDR_W >= 1);
    end

    scs_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flags     (flags),
        .rx_data   (rx_data),
        .bus_rdata (bus_rdata),
        .clr       (clr)
    );

    scs_rx_path #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_done  (rx_done),
        .rx_byte  (rx_byte),
        .rx_en    (rx_en),
        .clr_full (clr.full),
        .clr_ovr  (clr.ovr),
        .rx_full  (rx_full),
        .overrun  (overrun),
        .rx_data  (rx_data)
    );

    scs_err_flag u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_sig  (err_sig),
        .tx_en    (tx_en),
        .mode_t1  (mode_t1),
        .clr_err  (clr.err),
        .err_flag (err_flag)
    );

    always_comb begin
        flags.full = rx_full;
        flags.ovr  = overrun;
        flags.err  = err_flag;
    end

    AST_RESET_CLEAN: assert property (@(posedge clk)
        !rst_n |=> (!rx_full && !overrun && !err_flag)); // R1
endmodule

// File: tb/tb_scs_status_unit.sv
module tb_scs_status_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 2;
    localparam int NV = 17;

    typedef struct packed {
        logic [3:0] req;
        logic       rx;
        logic [7:0] byt;
        logic       ren;
        logic       es;
        logic       ten;
        logic       t1;
        logic       wr;
        logic [7:0] wd;
        logic       e_full;
        logic       e_ovr;
        logic       e_err;
        logic [7:0] e_data;
    } vec_t;

    // req, rx, byte, rx_en, err_sig, tx_en, t1, wr, wdata, full, ovr, err, data
    localparam vec_t VEC [NV] = '{
        '{4'd2,  1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hA5}, // R2 first byte
        '{4'd2,  1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hA5}, // R2 hold
        '{4'd3,  1'b1, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h3C}, // R3 overrun keeps new
        '{4'd4,  1'b1, 8'h77, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h3C}, // R4 blocked
        '{4'd5,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h3C}, // R5 rx_en off keeps
        '{4'd6,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h20, 1'b0, 1'b1, 1'b0, 8'h3C}, // R6 clear full only
        '{4'd4,  1'b1, 8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h3C}, // R4 still blocked
        '{4'd6,  1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 8'h3C}, // R6 clear overrun
        '{4'd5,  1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h3C}, // R5 ignored
        '{4'd7,  1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h3C}, // R7 error set
        '{4'd9,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h3C}, // R9 tx_en off keeps
        '{4'd6,  1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h3C}, // R6 clear error
        '{4'd8,  1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h3C}, // R8 T=1 silent
        '{4'd9,  1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h3C}, // R9 tx off ignored
        '{4'd10, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h3C}, // R10 err set wins
        '{4'd10, 1'b1, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'h5A}, // R10 full set wins
        '{4'd10, 1'b1, 8'h66, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 8'h66}  // R10 overrun set wins
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_done = 1'b0;
    logic [DW-1:0] rx_byte = '0;
    logic          rx_en = 1'b0;
    logic          tx_en = 1'b0;
    logic          mode_t1 = 1'b0;
    logic          err_sig = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          rx_full, overrun, err_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scs_status_unit #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
        .rx_en(rx_en), .tx_en(tx_en), .mode_t1(mode_t1), .err_sig(err_sig),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_full(rx_full), .overrun(overrun), .err_flag(err_flag)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock edge, then settle at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        rx_done = 1'b0; err_sig = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    function automatic logic [7:0] stat(input logic f, input logic o, input logic e);
        return {1'b0, f, o, e, 4'b0000};
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        string rq;
        // Reset state, R1
        step(); step();
        chk("R1", "rx_full", rx_full, 0);
        chk("R1", "overrun", overrun, 0);
        chk("R1", "err_flag", err_flag, 0);
        bus_addr = 2'd1;
        #1 chk("R1", "data reg", bus_rdata, 0);
        bus_addr = 2'd0;
        rst_n = 1'b1;
        step();

        // Vector table
        for (int i = 0; i < NV; i++) begin
            rx_done = VEC[i].rx; rx_byte = VEC[i].byt; rx_en = VEC[i].ren;
            err_sig = VEC[i].es; tx_en = VEC[i].ten; mode_t1 = VEC[i].t1;
            bus_wr = VEC[i].wr; bus_wdata = VEC[i].wd; bus_addr = 2'd0;
            step();
            idle_inputs();
            rq = $sformatf("R%0d v%0d", VEC[i].req, i);
            chk(rq, "rx_full", rx_full, VEC[i].e_full);
            chk(rq, "overrun", overrun, VEC[i].e_ovr);
            chk(rq, "err_flag", err_flag, VEC[i].e_err);
            // Status word layout, R6
            #1 chk(rq, "status word", bus_rdata, stat(VEC[i].e_full, VEC[i].e_ovr, VEC[i].e_err));
            bus_addr = 2'd1;
            #1 chk(rq, "data reg", bus_rdata, VEC[i].e_data);
            bus_addr = 2'd0;
        end

        // R11 read mux and R2 read does not clear
        bus_addr = 2'd1;
        #1 chk("R11", "addr1 data", bus_rdata, 8'h66);
        step();
        chk("R2", "full after data read", rx_full, 1);
        bus_addr = 2'd2;
        #1 chk("R11", "addr2 zero", bus_rdata, 0);
        bus_addr = 2'd3;
        #1 chk("R11", "addr3 zero", bus_rdata, 0);
        bus_addr = 2'd0;

        // R6 write to data address leaves flags alone
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h00;
        step(); idle_inputs(); bus_addr = 2'd0;
        chk("R6", "full after data-addr write", rx_full, 1);
        chk("R6", "overrun after data-addr write", overrun, 1);

        // R1 reset mid-run
        rst_n = 1'b0;
        step();
        chk("R1", "rx_full mid reset", rx_full, 0);
        chk("R1", "overrun mid reset", overrun, 0);
        bus_addr = 2'd1;
        #1 chk("R1", "data mid reset", bus_rdata, 0);
        bus_addr = 2'd0;
        rst_n = 1'b1;
        step();

        // R6 writing ones has no effect
        rx_done = 1'b1; rx_byte = 8'h81; rx_en = 1'b1;
        step(); idle_inputs();
        err_sig = 1'b1; tx_en = 1'b1; mode_t1 = 1'b0;
        step(); idle_inputs();
        bus_wr = 1'b1; bus_wdata = 8'hFF;
        step(); idle_inputs();
        chk("R6", "full after write ones", rx_full, 1);
        chk("R6", "err after write ones", err_flag, 1);
        chk("R6", "overrun after write ones", overrun, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule